// File: doc/BRIEF.md
# Calibration Step Sequencer

This block orders the calibration work of a successive-approximation converter. A host asks for a routine with a target bit and a two-bit routine selector, then pulses a start strobe. The sequencer turns that request into one, two or three single calibration steps and hands them one at a time to a separate calibration engine. The steps are DAC linearity, gain and offset. For each step it gives a one-cycle start pulse with a step code, then waits for the engine's one-cycle done pulse before it moves on.

The target bit applies to the gain and offset steps only. Internal means the converter's own gain and offset; system means gain and offset measured through the external signal path. The DAC step is always internal. Once the reset is released, the block runs the full internal routine by itself, with no host request. A busy flag covers the whole routine, and a one-cycle complete pulse marks its end. The arithmetic, coefficient storage and conversion itself live in the engine and are not part of this block.

Top module: `cal_seq_top`

## Requirements
- R1: After reset is released, and with no request, the block runs the full internal routine by itself. The step codes are 1, then 2, then 3.
- R2: Selector 00 runs DAC, gain, then offset. With req_sys=0 the codes are 1, 2, 3. With req_sys=1 they are 1, 4, 5.
- R3: Selector 01 runs gain, then offset, with no DAC step. With req_sys=0 the codes are 2, 3. With req_sys=1 they are 4, 5.
- R4: Selector 10 runs only offset (code 3 internal, 5 system). Selector 11 runs only gain (code 2 internal, 4 system).
- R5: step_start is high for exactly one cycle per step. The first step starts in the cycle after an accepted request. Each later step starts in the cycle after the previous step_done is sampled. step_code is 0 whenever step_start is low. Code values: 1 DAC, 2 internal gain, 3 internal offset, 4 system gain, 5 system offset.
- R6: busy is high from the first step_start cycle through the cycle in which the last step_done is sampled. It is low from the next cycle on.
- R7: A start request made while busy is ignored. This includes a request in the same cycle as the final step_done: no new step is issued afterwards.
- R8: cal_complete is high for exactly one cycle, in the cycle after the final step_done, and it is never high together with busy.
- R9: A step_done that arrives when the block is not waiting for one is ignored. This covers the idle state and the step_start cycle itself. The block keeps waiting for a later done.
- R10: While rst_n is low, busy, step_start and cal_complete are 0 and step_code is 0. Asserting rst_n in the middle of a routine aborts it. The next release starts the automatic routine of R1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle start strobe for a routine |
| req_sys | input | 1 | Target: 0 internal, 1 system (gain and offset steps) |
| req_sel | input | 2 | Routine selector: 00 full, 01 gain+offset, 10 offset, 11 gain |
| step_done | input | 1 | One-cycle done pulse from the calibration engine |
| step_start | output | 1 | One-cycle pulse that issues a step |
| step_code | output | 3 | Code of the issued step, 0 when no step is issued |
| busy | output | 1 | High while a routine is in progress |
| cal_complete | output | 1 | One-cycle pulse after the final step finishes |

## Verification
Two events can land in the same cycle: the engine's done pulse for the last step of a routine, and a new start request from the host. The bench drives both in one cycle. It expects the complete pulse in the next cycle and busy low, and it then watches several cycles for any step_start. Seeing none shows that the request was correctly ignored. A second overlap puts a done pulse in the very cycle a step is issued. The bench expects that done to be dropped, and it expects the sequencer to keep waiting until a later done arrives.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  localparam int CODE_W    = 3;
  localparam int SEL_W     = 2;
  localparam int MAX_STEPS = 3;
  localparam int IDX_W     = $clog2(MAX_STEPS + 1);

  typedef enum logic [CODE_W-1:0] {
    STEP_NONE  = 3'd0,
    STEP_DAC   = 3'd1,
    STEP_IGAIN = 3'd2,
    STEP_IOFS  = 3'd3,
    STEP_SGAIN = 3'd4,
    STEP_SOFS  = 3'd5
  } step_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_FULL     = 2'b00,
    SEL_GAIN_OFS = 2'b01,
    SEL_OFS      = 2'b10,
    SEL_GAIN     = 2'b11
  } sel_e;

  typedef struct packed {
    logic             sys;
    logic [SEL_W-1:0] sel;
  } cal_req_t;

  typedef logic [MAX_STEPS-1:0][CODE_W-1:0] plan_t;

  localparam cal_req_t DEFAULT_REQ = '{sys: 1'b0, sel: SEL_FULL};

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [STAGES-1:0] sh_q;

  // asserts at once, releases after STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sh_q[STAGES-1];

endmodule

// File: rtl/cal_plan_dec.sv
module cal_plan_dec
  import cal_seq_pkg::*;
(
  input  cal_req_t         req,
  output plan_t            plan,
  output logic [IDX_W-1:0] plan_len
);

  step_e gain_c;
  step_e ofs_c;

  always_comb begin
    gain_c = req.sys ? STEP_SGAIN : STEP_IGAIN;
    ofs_c  = req.sys ? STEP_SOFS  : STEP_IOFS;
    plan   = '0;
    unique case (sel_e'(req.sel))
      SEL_FULL: begin
        plan[0]  = STEP_DAC;
        plan[1]  = gain_c;
        plan[2]  = ofs_c;
        plan_len = IDX_W'(3);
      end
      SEL_GAIN_OFS: begin
        plan[0]  = gain_c;
        plan[1]  = ofs_c;
        plan_len = IDX_W'(2);
      end
      SEL_OFS: begin
        plan[0]  = ofs_c;
        plan_len = IDX_W'(1);
      end
      default: begin
        plan[0]  = gain_c;
        plan_len = IDX_W'(1);
      end
    endcase
  end

endmodule

// File: rtl/cal_step_fsm.sv
module cal_step_fsm
  import cal_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_s,
  input  logic              req_valid,
  input  cal_req_t          req_in,
  output cal_req_t          launch_req,
  input  plan_t             plan_codes,
  input  logic [IDX_W-1:0]  plan_len,
  input  logic              step_done,
  output logic              step_start,
  output logic [CODE_W-1:0] step_code,
  output logic              busy,
  output logic              cal_complete
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e              state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] len_q;
  plan_t            plan_q;
  logic             auto_q, auto_d;
  logic             cmpl_q, cmpl_d;
  logic             ld_plan;
  logic             last_step;

  assign launch_req = auto_q ? DEFAULT_REQ : req_in;
  assign last_step  = (idx_q == (len_q - 1'b1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    auto_d  = auto_q;
    cmpl_d  = 1'b0;
    ld_plan = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (auto_q || req_valid) begin
          ld_plan = 1'b1;
          idx_d   = '0;
          auto_d  = 1'b0;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (step_done) begin
          if (last_step) begin
            state_d = ST_IDLE;
            cmpl_d  = 1'b1;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      auto_q  <= 1'b1;
      cmpl_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      auto_q  <= auto_d;
      cmpl_q  <= cmpl_d;
    end
  end

  // plan registers, loaded only on launch
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      plan_q <= '0;
      len_q  <= '0;
    end else if (ld_plan) begin
      plan_q <= plan_codes;
      len_q  <= plan_len;
    end
  end

  assign step_start   = (state_q == ST_ISSUE);
  assign step_code    = step_start ? plan_q[idx_q] : STEP_NONE;
  assign busy         = (state_q != ST_IDLE);
  assign cal_complete = cmpl_q;

  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_s)
    step_start |=> !step_start);
  a_r5_code_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    !step_start |-> (step_code == STEP_NONE));
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_s)
    step_start |-> busy);
  a_r8_complete_single: assert property (@(posedge clk) disable iff (!rst_s)
    cal_complete |=> !cal_complete);
  a_r8_complete_idle: assert property (@(posedge clk) disable iff (!rst_s)
    cal_complete |-> !busy);
  a_r7_no_relaunch: assert property (@(posedge clk) disable iff (!rst_s)
    cal_complete |-> !step_start);

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_sys,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              step_done,
  output logic              step_start,
  output logic [CODE_W-1:0] step_code,
  output logic              busy,
  output logic              cal_complete
);

  logic             rst_s;
  cal_req_t         host_req;
  cal_req_t         launch_req;
  plan_t            plan_codes;
  logic [IDX_W-1:0] plan_len;

  assign host_req = '{sys: req_sys, sel: req_sel};

  cal_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  cal_plan_dec u_dec (
    .req      (launch_req),
    .plan     (plan_codes),
    .plan_len (plan_len)
  );

  cal_step_fsm u_fsm (
    .clk          (clk),
    .rst_s        (rst_s),
    .req_valid    (req_valid),
    .req_in       (host_req),
    .launch_req   (launch_req),
    .plan_codes   (plan_codes),
    .plan_len     (plan_len),
    .step_done    (step_done),
    .step_start   (step_start),
    .step_code    (step_code),
    .busy         (busy),
    .cal_complete (cal_complete)
  );

endmodule

// File: tb/sim_cal_seq_top.sv
module sim_cal_seq_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_sys;
  logic [1:0] req_sel;
  logic       step_done;
  logic       step_start;
  logic [2:0] step_code;
  logic       busy;
  logic       cal_complete;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_seq_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_sys      (req_sys),
    .req_sel      (req_sel),
    .step_done    (step_done),
    .step_start   (step_start),
    .step_code    (step_code),
    .busy         (busy),
    .cal_complete (cal_complete)
  );

  typedef struct packed {
    logic       sys;
    logic [1:0] sel;
    logic [1:0] n;
    logic [2:0] c0;
    logic [2:0] c1;
    logic [2:0] c2;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 2'b00, 2'd3, 3'd1, 3'd2, 3'd3},
    '{1'b0, 2'b01, 2'd2, 3'd2, 3'd3, 3'd0},
    '{1'b0, 2'b10, 2'd1, 3'd3, 3'd0, 3'd0},
    '{1'b0, 2'b11, 2'd1, 3'd2, 3'd0, 3'd0},
    '{1'b1, 2'b00, 2'd3, 3'd1, 3'd4, 3'd5},
    '{1'b1, 2'b01, 2'd2, 3'd4, 3'd5, 3'd0},
    '{1'b1, 2'b10, 2'd1, 3'd5, 3'd0, 3'd0},
    '{1'b1, 2'b11, 2'd1, 3'd4, 3'd0, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_req(input logic sys, input logic [1:0] sel);
    @(negedge clk);
    req_valid = 1'b1; req_sys = sys; req_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_start(input string req);
    int lat = 0;
    while (!step_start && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(step_start === 1'b1, req, "step_start seen", int'(step_start), 1);
  endtask

  // called at the negedge where the first step_start should be visible
  task automatic run_routine(input logic [2:0] e0, e1, e2, input int n,
                             input int dly, input string req, input bit overlap);
    logic [2:0] exp_c [3];
    exp_c[0] = e0; exp_c[1] = e1; exp_c[2] = e2;
    for (int i = 0; i < n; i++) begin
      chk(step_start === 1'b1, "R5", "start one cycle after request/done",
          int'(step_start), 1);
      if (!step_start) wait_start("R5");
      chk(step_code === exp_c[i], req, "step code", int'(step_code), int'(exp_c[i]));
      chk(busy === 1'b1, "R6", "busy during start", int'(busy), 1);
      @(negedge clk);
      chk(step_start === 1'b0, "R5", "start is single cycle", int'(step_start), 0);
      chk(step_code === 3'd0, "R5", "code zero while waiting", int'(step_code), 0);
      for (int d = 0; d < dly; d++) begin
        chk(busy === 1'b1 && cal_complete === 1'b0, "R6", "busy while waiting",
            int'(busy), 1);
        @(negedge clk);
      end
      step_done = 1'b1;
      if (overlap && i == n - 1) begin
        req_valid = 1'b1; req_sys = 1'b1; req_sel = 2'b11;
      end
      @(negedge clk);
      step_done = 1'b0;
      req_valid = 1'b0;
    end
    chk(cal_complete === 1'b1, "R8", "complete after last done", int'(cal_complete), 1);
    chk(busy === 1'b0, "R6", "busy low after last done", int'(busy), 0);
    @(negedge clk);
    chk(cal_complete === 1'b0, "R8", "complete is single cycle", int'(cal_complete), 0);
    for (int k = 0; k < 4; k++) begin
      chk(step_start === 1'b0 && busy === 1'b0, "R7", "no step after routine ends",
          int'(step_start), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_sys = 1'b0; req_sel = 2'b00; step_done = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy === 1'b0, "R10", "busy in reset", int'(busy), 0);
    chk(step_start === 1'b0, "R10", "start in reset", int'(step_start), 0);
    chk(step_code === 3'd0, "R10", "code in reset", int'(step_code), 0);
    chk(cal_complete === 1'b0, "R10", "complete in reset", int'(cal_complete), 0);

    // R1: automatic routine after reset release
    rst_n = 1'b1;
    wait_start("R1");
    run_routine(3'd1, 3'd2, 3'd3, 3, 2, "R1", 1'b0);

    // R9: stray done while idle
    @(negedge clk); step_done = 1'b1;
    @(negedge clk); step_done = 1'b0;
    chk(busy === 1'b0 && step_start === 1'b0, "R9", "idle done ignored", int'(busy), 0);
    @(negedge clk);
    chk(cal_complete === 1'b0, "R9", "idle done no complete", int'(cal_complete), 0);

    // R2, R3, R4: table of routines
    for (int v = 0; v < 8; v++) begin
      string tag;
      tag = (VECS[v].sel == 2'b00) ? "R2" : (VECS[v].sel == 2'b01) ? "R3" : "R4";
      pulse_req(VECS[v].sys, VECS[v].sel);
      run_routine(VECS[v].c0, VECS[v].c1, VECS[v].c2, int'(VECS[v].n), v % 3, tag, 1'b0);
    end

    // R7: request in the same cycle as final done
    pulse_req(1'b0, 2'b00);
    run_routine(3'd1, 3'd2, 3'd3, 3, 1, "R2", 1'b1);

    // R7: request while waiting on a step
    pulse_req(1'b0, 2'b11);
    chk(step_code === 3'd2, "R4", "gain only code", int'(step_code), 2);
    @(negedge clk);
    req_valid = 1'b1; req_sys = 1'b1; req_sel = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    chk(step_start === 1'b0 && busy === 1'b1, "R7", "busy request ignored",
        int'(step_start), 0);
    step_done = 1'b1;
    @(negedge clk); step_done = 1'b0;
    chk(cal_complete === 1'b1, "R7", "single step finished", int'(cal_complete), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(step_start === 1'b0, "R7", "ignored request not replayed", int'(step_start), 0);
    end

    // R9: done in the issue cycle is dropped
    pulse_req(1'b1, 2'b10);
    chk(step_code === 3'd5, "R4", "system offset only code", int'(step_code), 5);
    step_done = 1'b1;
    @(negedge clk); step_done = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(busy === 1'b1 && cal_complete === 1'b0, "R9", "done in issue cycle ignored",
          int'(busy), 1);
      @(negedge clk);
    end
    step_done = 1'b1;
    @(negedge clk); step_done = 1'b0;
    chk(cal_complete === 1'b1, "R9", "later done completes", int'(cal_complete), 1);

    // R10: reset in mid-routine, then automatic routine again
    pulse_req(1'b1, 2'b00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy === 1'b0 && step_start === 1'b0, "R10", "reset aborts routine", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_start("R10");
    run_routine(3'd1, 3'd2, 3'd3, 3, 0, "R1", 1'b0);

    ended = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule